// File: doc/BRIEF.md
# Conversion Result Bank with Direct, Rotating and Queued Readout

This block holds the results produced by a dual-converter scheduler. The scheduler delivers one pair of 12-bit results at a time, one result for each input of a channel group (A, B or C). The bank keeps the latest result of each of the six inputs. It also keeps a six-entry queue of results in the order they arrived. A host reads the bank through a parallel port with active-low select and read strobe.

Every read returns a 16-bit word: a valid flag, a 3-bit input code and the 12-bit result. A 3-bit address/mode value chooses how each read is served:
- a fixed input is read directly;
- a rotating pointer walks through all six inputs;
- the oldest queued entry is read and then removed.

For 8-bit hosts, a byte mode splits each word into two accesses. A result that arrives while a read is in progress is held back. It is written once the read strobe is released. The bus driver is modelled as an output-enable flag.

Top module: `conv_result_bank`

## Requirements
- R1: The output word carries the valid flag in bit 15, the input code in bits 14..12 and the result in bits 11..0 (MSB at bit 11). In the direct and rotating modes, the valid flag is 1 once that input has been written since reset.
- R2: Input codes are A0=0, A1=1, B0=2, B1=3, C0=4, C1=5. A delivered pair with group index 0/1/2 (A/B/C) writes its first result to input X0 and its second result to input X1.
- R3: Address/mode values 0 to 5 read the input whose code equals the value.
- R4: Mode 6 returns inputs 0,1,2,3,4,5 on successive completed reads, then wraps to 0. The pointer is 0 after reset.
- R5: Every delivered pair is also appended to the queue, X0 first and then X1. Mode 7 returns the oldest entry. A completed mode-7 read removes that entry and moves the others down by one.
- R6: In mode 7 the word has the valid flag set while the queue is non-empty. When the queue is empty the word reads 0x0000, and completing a read does nothing.
- R7: A pair delivered while select and read are both low is not visible until the read strobe has returned high. It is then written with no loss.
- R8: With byte mode high, successive accesses return the low byte and then the high byte of the word, each in bits 7..0 with bits 15..8 zero.
- R9: The rotating pointer and the queue advance only when a whole word is completed. In byte mode this is the second access.
- R10: Reset clears all stored results, the queue, the pointer, the byte phase and the overflow flag, and sets the held mode to 0.
- R11: The address/mode input is captured only while select and read are both low. A read completes when the read strobe rises with select still low, and it acts on the captured mode, whatever the input shows at that moment.
- R12: A pair that would take the queue past its depth (six) is dropped from the queue, and a sticky overflow flag is set. The stored results per input are still updated.
- R13: The data-enable output is high, and the data output shows the selected word, in the cycle after a clock edge that samples select and read low. Otherwise the data-enable output is low and the data output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| resValid | input | 1 | A result pair is delivered this cycle |
| resPair | input | 2 | Group index of the pair (0=A, 1=B, 2=C) |
| resData0 | input | 12 | Result for input X0 of the group |
| resData1 | input | 12 | Result for input X1 of the group |
| csN | input | 1 | Active-low select |
| rdN | input | 1 | Active-low read strobe |
| addrMode | input | 3 | Input code 0..5, 6 = rotate, 7 = queue |
| byteMode | input | 1 | Split each word into two 8-bit accesses |
| dataOut | output | 16 | Registered read word |
| dataOe | output | 1 | Read word is being driven |
| fifoOverflow | output | 1 | Sticky: a pair was dropped from the queue |

## Verification
A wrong rotating pointer or byte phase is not visible in the read that caused it. It shows on the next completed read, as the wrong input code in bits 14..12 or as the wrong half of the word. A corrupted queue shows as an entry out of arrival order, or as a valid flag that drops too early or too late. This is seen within at most six further queue reads. A missed deferral shows within two cycles of the delivery, as new data while the strobe is still held low.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int DATA_W   = 12;
  localparam int CODE_W   = 3;
  localparam int WORD_W   = 1 + CODE_W + DATA_W;
  localparam int NUM_CH   = 6;
  localparam int NUM_SLOT = 1 << CODE_W;
  localparam int GRP_W    = 2;

  localparam logic [CODE_W-1:0] MODE_CYCLE = 3'd6;
  localparam logic [CODE_W-1:0] MODE_FIFO  = 3'd7;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [DATA_W-1:0] data;
  } rbEntry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              loadPend;
    logic              commit;
    logic              fromPend;
    logic              pop;
    logic              outEn;
    logic              byteMode;
    logic              byteHi;
    logic [CODE_W-1:0] cyclePtr;
    logic [CODE_W-1:0] selMode;
  } rbStrobe_t;
endpackage

// File: rtl/rb_ctrl.sv
module rb_ctrl
  import rb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              resValid,
  input  logic [GRP_W-1:0]  resPair,
  input  logic              csN,
  input  logic              rdN,
  input  logic [CODE_W-1:0] addrMode,
  input  logic              byteMode,
  input  logic              fifoEmpty,
  output rbStrobe_t         strb
);
  logic              readActive;
  logic              rdLowQ;
  logic              halfQ;
  logic              pendQ;
  logic [CODE_W-1:0] modeQ;
  logic [CODE_W-1:0] ptrQ;
  logic              readDone;
  logic              wordDone;
  logic              incoming;

  assign readActive = !csN && !rdN;
  assign readDone   = rdLowQ && !rdN ? 1'b0 : (rdLowQ && rdN && !csN);
  assign wordDone   = readDone && (!byteMode || halfQ);
  assign incoming   = resValid && (resPair != 2'd3);

  always_comb begin
    strb          = '0;
    strb.outEn    = readActive;
    strb.selMode  = addrMode;
    strb.byteMode = byteMode;
    strb.byteHi   = halfQ;
    strb.cyclePtr = ptrQ;
    strb.pop      = wordDone && (modeQ == MODE_FIFO) && !fifoEmpty;
    if (readActive) begin
      strb.loadPend = incoming && !pendQ;
    end else if (pendQ) begin
      strb.commit   = 1'b1;
      strb.fromPend = 1'b1;
      strb.loadPend = incoming;
    end else begin
      strb.commit   = incoming;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdLowQ <= 1'b0;
      halfQ  <= 1'b0;
      pendQ  <= 1'b0;
      modeQ  <= '0;
      ptrQ   <= '0;
    end else begin
      rdLowQ <= readActive;
      if (readActive) modeQ <= addrMode;
      if (strb.loadPend) pendQ <= 1'b1;
      else if (strb.commit && strb.fromPend) pendQ <= 1'b0;
      if (readDone) halfQ <= byteMode ? !halfQ : 1'b0;
      if (wordDone && modeQ == MODE_CYCLE)
        ptrQ <= (ptrQ == CODE_W'(NUM_CH - 1)) ? '0 : ptrQ + 1'b1;
    end
  end

  // R4: rotating pointer never leaves the six input codes
  assert_ptr_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    ptrQ < CODE_W'(NUM_CH));

  // R9: in byte mode the pointer holds across the first access
  assert_ptr_hold_first_byte_R9: assert property (@(posedge clk) disable iff (!rstN)
    (readDone && byteMode && !halfQ) |=> $stable(ptrQ));
endmodule

// File: rtl/rb_datapath.sv
module rb_datapath
  import rb_pkg::*;
#(
  parameter int FIFO_DEPTH = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  rbStrobe_t         strb,
  input  logic [GRP_W-1:0]  resPair,
  input  logic [DATA_W-1:0] resData0,
  input  logic [DATA_W-1:0] resData1,
  output logic              fifoEmpty,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataOe,
  output logic              fifoOverflow
);
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
  localparam int HALF_W = WORD_W / 2;

  logic [GRP_W-1:0]  pendPair;
  logic [DATA_W-1:0] pendD0, pendD1;
  logic [GRP_W-1:0]  wrPair;
  logic [DATA_W-1:0] wrD0, wrD1;

  assign wrPair = strb.fromPend ? pendPair : resPair;
  assign wrD0   = strb.fromPend ? pendD0   : resData0;
  assign wrD1   = strb.fromPend ? pendD1   : resData1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendPair <= '0;
      pendD0   <= '0;
      pendD1   <= '0;
    end else if (strb.loadPend) begin
      pendPair <= resPair;
      pendD0   <= resData0;
      pendD1   <= resData1;
    end
  end

  // per-input latest result; codes 6 and 7 are tied empty
  logic [DATA_W-1:0] dirData [NUM_SLOT];
  logic [NUM_SLOT-1:0] dirValid;

  generate
    for (genvar g = 0; g < NUM_SLOT; g++) begin : gSlot
      if (g < NUM_CH) begin : gReal
        logic [DATA_W-1:0] slotQ;
        logic              slotV;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            slotQ <= '0;
            slotV <= 1'b0;
          end else if (strb.commit && wrPair == GRP_W'(g / 2)) begin
            slotQ <= (g % 2 == 0) ? wrD0 : wrD1;
            slotV <= 1'b1;
          end
        end
        assign dirData[g]  = slotQ;
        assign dirValid[g] = slotV;
      end else begin : gTie
        assign dirData[g]  = '0;
        assign dirValid[g] = 1'b0;
      end
    end
  endgenerate

  // arrival-ordered queue
  rbEntry_t          fifoQ [FIFO_DEPTH];
  rbEntry_t          nextQ [FIFO_DEPTH];
  logic [CNT_W-1:0]  cntQ;
  int                nextCnt;
  logic              ovfSet;

  assign fifoEmpty = (cntQ == '0);

  always_comb begin
    nextQ   = fifoQ;
    nextCnt = int'(cntQ);
    ovfSet  = 1'b0;
    if (strb.pop) begin
      for (int i = 0; i < FIFO_DEPTH - 1; i++) nextQ[i] = fifoQ[i + 1];
      nextQ[FIFO_DEPTH - 1] = '0;
      nextCnt = nextCnt - 1;
    end
    if (strb.commit) begin
      if (nextCnt + 2 <= FIFO_DEPTH) begin
        for (int i = 0; i < FIFO_DEPTH; i++) begin
          if (i == nextCnt)     nextQ[i] = '{code: {wrPair, 1'b0}, data: wrD0};
          if (i == nextCnt + 1) nextQ[i] = '{code: {wrPair, 1'b1}, data: wrD1};
        end
        nextCnt = nextCnt + 2;
      end else begin
        ovfSet = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < FIFO_DEPTH; i++) fifoQ[i] <= '0;
      cntQ         <= '0;
      fifoOverflow <= 1'b0;
    end else begin
      fifoQ <= nextQ;
      cntQ  <= CNT_W'(nextCnt);
      if (ovfSet) fifoOverflow <= 1'b1;
    end
  end

  // read word selection
  logic [WORD_W-1:0] word;
  logic [CODE_W-1:0] ch;

  always_comb begin
    ch   = (strb.selMode == MODE_CYCLE) ? strb.cyclePtr : strb.selMode;
    word = {dirValid[ch], ch, dirData[ch]};
    if (strb.selMode == MODE_FIFO)
      word = fifoEmpty ? '0 : {1'b1, fifoQ[0]};
    if (strb.byteMode)
      word = strb.byteHi ? {{HALF_W{1'b0}}, word[WORD_W-1:HALF_W]}
                         : {{HALF_W{1'b0}}, word[HALF_W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
      dataOe  <= 1'b0;
    end else begin
      dataOut <= strb.outEn ? word : '0;
      dataOe  <= strb.outEn;
    end
  end

  assert_fifo_bound_R12: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_W'(FIFO_DEPTH));

  assert_ovf_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    fifoOverflow |=> fifoOverflow);

  assert_pop_shrinks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && !strb.commit) |=> cntQ == CNT_W'($past(cntQ) - 1'b1));
endmodule

// File: rtl/conv_result_bank.sv
module conv_result_bank
  import rb_pkg::*;
#(
  parameter int FIFO_DEPTH = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resValid,
  input  logic [1:0]        resPair,
  input  logic [11:0]       resData0,
  input  logic [11:0]       resData1,
  input  logic              csN,
  input  logic              rdN,
  input  logic [2:0]        addrMode,
  input  logic              byteMode,
  output logic [15:0]       dataOut,
  output logic              dataOe,
  output logic              fifoOverflow
);
  rbStrobe_t strb;
  logic      fifoEmpty;

  rb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .resValid (resValid),
    .resPair  (resPair),
    .csN      (csN),
    .rdN      (rdN),
    .addrMode (addrMode),
    .byteMode (byteMode),
    .fifoEmpty(fifoEmpty),
    .strb     (strb)
  );

  rb_datapath #(.FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .resPair     (resPair),
    .resData0    (resData0),
    .resData1    (resData1),
    .fifoEmpty   (fifoEmpty),
    .dataOut     (dataOut),
    .dataOe      (dataOe),
    .fifoOverflow(fifoOverflow)
  );

  // R13: a sampled read drives the bus in the next cycle, an idle one does not
  assert_oe_follows_read_R13: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rdN) |=> dataOe);

  assert_oe_idle_R13: assert property (@(posedge clk) disable iff (!rstN)
    !(!csN && !rdN) |=> !dataOe);
endmodule

// File: tb/conv_result_bank_tb.sv
`timescale 1ns/1ps
module conv_result_bank_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resValid = 1'b0;
  logic [1:0]  resPair = '0;
  logic [11:0] resData0 = '0, resData1 = '0;
  logic        csN = 1'b1, rdN = 1'b1;
  logic [2:0]  addrMode = '0;
  logic        byteMode = 1'b0;
  logic [15:0] dataOut;
  logic        dataOe;
  logic        fifoOverflow;

  int totalCnt = 0;
  int failCnt  = 0;

  always #2.5 clk = ~clk;

  conv_result_bank u_dut (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resPair(resPair),
    .resData0(resData0), .resData1(resData1), .csN(csN), .rdN(rdN),
    .addrMode(addrMode), .byteMode(byteMode), .dataOut(dataOut),
    .dataOe(dataOe), .fifoOverflow(fifoOverflow)
  );

  // reference model
  logic [11:0] mDir [6];
  logic        mVal [6];
  logic [14:0] mQ   [6];
  int          mCnt, mPtr;
  bit          mHalf, mOvf;

  task automatic mClear();
    for (int i = 0; i < 6; i++) begin mDir[i] = '0; mVal[i] = 1'b0; mQ[i] = '0; end
    mCnt = 0; mPtr = 0; mHalf = 0; mOvf = 0;
  endtask

  task automatic mWrite(input int p, input logic [11:0] d0, input logic [11:0] d1);
    mDir[2*p] = d0; mDir[2*p+1] = d1; mVal[2*p] = 1'b1; mVal[2*p+1] = 1'b1;
    if (mCnt + 2 <= 6) begin
      mQ[mCnt]   = {3'(2*p), d0};
      mQ[mCnt+1] = {3'(2*p+1), d1};
      mCnt += 2;
    end else mOvf = 1;
  endtask

  function automatic logic [15:0] mExp(input logic [2:0] mode, input bit byt);
    logic [15:0] w;
    logic [2:0]  ch;
    if (mode == 3'd7) w = (mCnt > 0) ? {1'b1, mQ[0]} : 16'h0;
    else begin
      ch = (mode == 3'd6) ? 3'(mPtr) : mode;
      w  = {mVal[ch], ch, mDir[ch]};
    end
    if (byt) w = mHalf ? {8'h0, w[15:8]} : {8'h0, w[7:0]};
    return w;
  endfunction

  task automatic mComplete(input logic [2:0] mode, input bit byt);
    bit adv;
    if (byt) begin adv = mHalf; mHalf = !mHalf; end
    else begin adv = 1; mHalf = 0; end
    if (adv && mode == 3'd6) mPtr = (mPtr + 1) % 6;
    if (adv && mode == 3'd7 && mCnt > 0) begin
      for (int i = 0; i < 5; i++) mQ[i] = mQ[i+1];
      mQ[5] = '0;
      mCnt--;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    totalCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; resValid = 0; csN = 1; rdN = 1; addrMode = 0; byteMode = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mClear();
    @(negedge clk);
  endtask

  task automatic doWrite(input int p, input logic [11:0] d0, input logic [11:0] d1);
    @(negedge clk);
    resValid = 1; resPair = 2'(p); resData0 = d0; resData1 = d1;
    @(negedge clk);
    resValid = 0;
    mWrite(p, d0, d1);
  endtask

  task automatic doRead(input logic [2:0] mode, input bit byt, input string tag);
    logic [15:0] e;
    @(negedge clk);
    addrMode = mode; byteMode = byt; csN = 0; rdN = 0;
    @(negedge clk);
    e = mExp(mode, byt);
    chk(dataOut == e && dataOe, tag, dataOut, e);
    rdN = 1;
    @(negedge clk);
    csN = 1;
    mComplete(mode, byt);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    failCnt++; totalCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    logic [15:0] e;
    void'($urandom(32'h5EED_0042));
    doReset();

    // R10 / R13: reset state
    chk(dataOe == 1'b0 && dataOut == 16'h0, "R13 idle bus after reset", dataOut, 16'h0);
    chk(fifoOverflow == 1'b0, "R10 overflow clear after reset", {15'h0, fifoOverflow}, 16'h0);
    doRead(3'd0, 0, "R10 empty input reads zero");
    doRead(3'd7, 0, "R6 empty queue reads zero");

    // R1 R2 R3: direct reads
    doWrite(0, 12'h123, 12'h456);
    doWrite(1, 12'h789, 12'hABC);
    doWrite(2, 12'hDEF, 12'h001);
    for (int c = 0; c < 6; c++) doRead(3'(c), 0, "R1 R2 R3 direct read");

    // R4: rotation and wrap
    for (int k = 0; k < 7; k++) doRead(3'd6, 0, "R4 rotating order");

    // R5 R6: queue order then empty
    for (int k = 0; k < 7; k++) doRead(3'd7, 0, "R5 R6 queue order");

    // R8: byte halves
    doRead(3'd3, 1, "R8 low byte");
    doRead(3'd3, 1, "R8 high byte");
    // R9: pointer advances only after second byte
    doRead(3'd6, 1, "R9 first byte rotate");
    doRead(3'd6, 1, "R9 second byte same input");
    doRead(3'd6, 1, "R9 next input after full word");
    doRead(3'd6, 1, "R9 next input high byte");

    // R7: delivery during a read is deferred
    @(negedge clk);
    addrMode = 3'd0; byteMode = 0; csN = 0; rdN = 0;
    @(negedge clk);
    e = mExp(3'd0, 0);
    resValid = 1; resPair = 2'd0; resData0 = 12'h5A5; resData1 = 12'h3C3;
    chk(dataOut == e, "R7 old data at read start", dataOut, e);
    @(negedge clk);
    resValid = 0;
    chk(dataOut == e, "R7 old data while strobe low", dataOut, e);
    @(negedge clk);
    chk(dataOut == e, "R7 still old data while strobe low", dataOut, e);
    rdN = 1;
    @(negedge clk);
    csN = 1;
    mComplete(3'd0, 0);
    mWrite(0, 12'h5A5, 12'h3C3);
    doRead(3'd0, 0, "R7 new data after release");
    doRead(3'd1, 0, "R7 second result after release");

    // R11: completion uses captured mode
    @(negedge clk);
    addrMode = 3'd6; byteMode = 0; csN = 0; rdN = 0;
    @(negedge clk);
    e = mExp(3'd6, 0);
    chk(dataOut == e, "R11 rotate read", dataOut, e);
    rdN = 1; addrMode = 3'd0;
    @(negedge clk);
    csN = 1;
    mComplete(3'd6, 0);
    repeat (2) @(negedge clk);
    doRead(3'd6, 0, "R11 pointer moved under captured mode");

    // R12: overflow
    doReset();
    doWrite(0, 12'h111, 12'h222);
    doWrite(1, 12'h333, 12'h444);
    doWrite(2, 12'h555, 12'h666);
    @(negedge clk);
    chk(fifoOverflow == 1'b0, "R12 full queue no overflow", {15'h0, fifoOverflow}, 16'h0);
    doWrite(0, 12'h777, 12'h888);
    @(negedge clk);
    chk(fifoOverflow == 1'b1, "R12 overflow flag set", {15'h0, fifoOverflow}, 16'h1);
    doRead(3'd0, 0, "R12 direct input still updated");
    for (int k = 0; k < 7; k++) doRead(3'd7, 0, "R12 queue keeps first six");
    chk(fifoOverflow == 1'b1, "R12 overflow flag sticky", {15'h0, fifoOverflow}, 16'h1);

    // constrained random mix
    doReset();
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 9) < 4)
        doWrite(int'($urandom_range(0, 2)), 12'($urandom), 12'($urandom));
      else
        doRead(3'($urandom_range(0, 7)), bit'($urandom_range(0, 3) == 0), "R3 R4 R5 R8 random read");
    end
    @(negedge clk);
    chk(fifoOverflow == mOvf, "R12 random overflow flag", {15'h0, fifoOverflow}, {15'h0, mOvf});
    chk(dataOe == 1'b0, "R13 idle after random run", {15'h0, dataOe}, 16'h0);

    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end
endmodule